// File: doc/BRIEF.md
# Compare and Truth-Flag Unit

This block holds the single truth bit that gates conditional execution in a small 8-bit processor. When a compare instruction is issued, the block evaluates one of six unsigned relational tests between two register operands. The outcome is captured in the truth register on the next rising clock edge.

Every instruction carries a 2-bit conditional code. The block turns that code and the current truth bit into an execute-permit signal, which the rest of the pipeline uses to commit or squash the instruction. A compare instruction is itself conditional: it updates the truth bit only when its own code permits it to execute.

Top module: `cmp_truth_unit`

## Requirements
- R1: While rst_ni is low, the truth register is 0 and truth_o reads 0.
- R2: Test selectors 000 (less than), 001 (less or equal), 010 (greater than) and 011 (greater or equal) compare lhs_i against rhs_i as unsigned numbers. The result is written to truth_o on the next rising edge.
- R3: Selector 100 stores 1 when lhs_i equals rhs_i. Selector 101 stores 1 when they differ.
- R4: Selectors 110 and 111 leave truth_o unchanged, even when cmp_en_i is high and the instruction may execute.
- R5: When cmp_en_i is low, truth_o keeps its value across a rising edge.
- R6: Conditional code 00 drives exec_ok_o high whatever the truth bit holds.
- R7: Code 01 drives exec_ok_o equal to truth_o. Code 10 drives exec_ok_o equal to the inverse of truth_o.
- R8: Code 11 drives exec_ok_o low and cond_rsvd_o high in the same cycle. Every other code drives cond_rsvd_o low.
- R9: A compare whose own conditional code denies execution leaves truth_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_en_i | input | 1 | Compare instruction strobe |
| lhs_i | input | 8 | Left operand |
| rhs_i | input | 8 | Right operand |
| test_sel_i | input | 3 | Relational test selector |
| cond_i | input | 2 | Conditional code of the current instruction |
| truth_o | output | 1 | Current truth register value |
| exec_ok_o | output | 1 | Execute permit for the current instruction |
| cond_rsvd_o | output | 1 | Reserved conditional code seen this cycle |

## Verification
The bench builds the block with the default operand width of 8 bits. At that width the operand extremes 0, 1, 127, 128 and 255 can be driven directly. The bench sweeps those values in pairs against all eight selector codes, so every equal, adjacent and sign-boundary case is covered for each test. Patterns that set the truth bit and then clear it, each followed by compares under all four conditional codes, exercise how the predicate on a compare interacts with the flag it writes.

// File: rtl/cmp_truth_pkg.sv
package cmp_truth_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned COND_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LT  = 3'b000,
    SEL_LE  = 3'b001,
    SEL_GT  = 3'b010,
    SEL_GE  = 3'b011,
    SEL_EQ  = 3'b100,
    SEL_NE  = 3'b101,
    SEL_NA0 = 3'b110,
    SEL_NA1 = 3'b111
  } test_sel_e;

  typedef enum logic [COND_W-1:0] {
    COND_ALWAYS = 2'b00,
    COND_IF_T   = 2'b01,
    COND_IF_F   = 2'b10,
    COND_RSVD   = 2'b11
  } cond_e;
endpackage

// File: rtl/cmp_relation.sv
module cmp_relation
  import cmp_truth_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              rel_o,
  output logic              sel_valid_o
);
  logic lt, eq;

  assign lt = lhs_i < rhs_i;
  assign eq = lhs_i == rhs_i;

  always_comb begin
    rel_o       = 1'b0;
    sel_valid_o = 1'b1;
    unique case (test_sel_e'(sel_i))
      SEL_LT:  rel_o = lt;
      SEL_LE:  rel_o = lt | eq;
      SEL_GT:  rel_o = ~(lt | eq);
      SEL_GE:  rel_o = ~lt;
      SEL_EQ:  rel_o = eq;
      SEL_NE:  rel_o = ~eq;
      default: sel_valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_cond_gate.sv
module cmp_cond_gate
  import cmp_truth_pkg::*;
(
  input  logic              truth_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              exec_ok_o,
  output logic              rsvd_o
);
  always_comb begin
    exec_ok_o = 1'b0;
    rsvd_o    = 1'b0;
    unique case (cond_e'(cond_i))
      COND_ALWAYS: exec_ok_o = 1'b1;
      COND_IF_T:   exec_ok_o = truth_i;
      COND_IF_F:   exec_ok_o = ~truth_i;
      default:     rsvd_o    = 1'b1;  // reserved: never execute
    endcase
  end
endmodule

// File: rtl/cmp_truth_unit.sv
module cmp_truth_unit
  import cmp_truth_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic [SEL_W-1:0]  test_sel_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              truth_o,
  output logic              exec_ok_o,
  output logic              cond_rsvd_o
);
  logic truth_q;
  logic rel, sel_valid, upd;

  cmp_relation #(.DATA_W(DATA_W)) u_rel (
    .lhs_i      (lhs_i),
    .rhs_i      (rhs_i),
    .sel_i      (test_sel_i),
    .rel_o      (rel),
    .sel_valid_o(sel_valid)
  );

  cmp_cond_gate u_gate (
    .truth_i  (truth_q),
    .cond_i   (cond_i),
    .exec_ok_o(exec_ok_o),
    .rsvd_o   (cond_rsvd_o)
  );

  // compare is itself predicated on its own conditional code
  assign upd = cmp_en_i & exec_ok_o & sel_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  truth_q <= 1'b0;
    else if (upd) truth_q <= rel;
  end

  assign truth_o = truth_q;
endmodule

// File: rtl/cmp_truth_checker.sv
module cmp_truth_checker
  import cmp_truth_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmp_en_i,
  input logic [DATA_W-1:0] lhs_i,
  input logic [DATA_W-1:0] rhs_i,
  input logic [SEL_W-1:0]  test_sel_i,
  input logic [COND_W-1:0] cond_i,
  input logic              truth_o,
  input logic              exec_ok_o,
  input logic              cond_rsvd_o
);
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> $stable(truth_o));

  assert_unused_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_sel_i[2:1] == 2'b11) |=> $stable(truth_o));

  assert_denied_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_ok_o |=> $stable(truth_o));

  assert_always_exec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 2'b00) |-> exec_ok_o);

  assert_rsvd_never_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 2'b11) |-> (!exec_ok_o && cond_rsvd_o));

  assert_if_true_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 2'b01) |-> (exec_ok_o == truth_o));

  assert_eq_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && exec_ok_o && test_sel_i == 3'b100)
      |=> (truth_o == ($past(lhs_i) == $past(rhs_i))));

  assert_lt_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en_i && exec_ok_o && test_sel_i == 3'b000)
      |=> (truth_o == ($past(lhs_i) < $past(rhs_i))));

  always_comb begin
    if (!rst_ni) assert_reset_clear_R1: assert (!truth_o);
  end
endmodule

bind cmp_truth_unit cmp_truth_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmp_en_i   (cmp_en_i),
  .lhs_i      (lhs_i),
  .rhs_i      (rhs_i),
  .test_sel_i (test_sel_i),
  .cond_i     (cond_i),
  .truth_o    (truth_o),
  .exec_ok_o  (exec_ok_o),
  .cond_rsvd_o(cond_rsvd_o)
);

// File: tb/cmp_truth_unit_bench.sv
module cmp_truth_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;

  typedef struct {
    logic  truth_nx;
    logic  exec_ok;
    logic  rsvd;
    string req_t;
    string req_c;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmp_en = 1'b0;
  logic [DATA_W-1:0] lhs = '0, rhs = '0;
  logic [2:0]        sel = '0;
  logic [1:0]        cond = '0;
  logic              truth, exec_ok, rsvd;

  int    n_checks = 0, n_errors = 0;
  logic  model_truth = 1'b0;
  item_t sb_q[$];
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_truth_unit #(.DATA_W(DATA_W)) u_cmp_truth_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmp_en_i(cmp_en), .lhs_i(lhs), .rhs_i(rhs),
    .test_sel_i(sel), .cond_i(cond), .truth_o(truth), .exec_ok_o(exec_ok),
    .cond_rsvd_o(rsvd)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b (sel=%0d cond=%0d lhs=%0d rhs=%0d)",
               req, act, exp, sel, cond, lhs, rhs);
    end
  endtask

  function automatic logic rel_model(input logic [2:0] s, input int a, input int b,
                                     output logic valid);
    valid = 1'b1;
    case (s)
      3'd0: return a < b;
      3'd1: return a <= b;
      3'd2: return a > b;
      3'd3: return a >= b;
      3'd4: return a == b;
      3'd5: return a != b;
      default: begin valid = 1'b0; return 1'b0; end
    endcase
  endfunction

  // driver: applies one instruction at negedge, pushes the expectation
  task automatic drive(input logic en, input int a, input int b,
                       input logic [2:0] s, input logic [1:0] c, input string req_t);
    item_t it;
    logic  r, v, ex;
    @(negedge clk);
    cmp_en = en; lhs = DATA_W'(a); rhs = DATA_W'(b); sel = s; cond = c;
    ex = (c == 2'b00) ? 1'b1 : (c == 2'b01) ? model_truth :
         (c == 2'b10) ? ~model_truth : 1'b0;
    r = rel_model(s, a, b, v);
    if (en && ex && v) model_truth = r;
    it.truth_nx = model_truth;
    it.exec_ok  = ex;
    it.rsvd     = (c == 2'b11);
    it.req_t    = req_t;
    it.req_c    = (c == 2'b00) ? "R6" : (c == 2'b11) ? "R8" : "R7";
    sb_q.push_back(it);
  endtask

  // monitor: combinational outputs mid low phase, truth after the edge
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() != 0) begin
        it = sb_q.pop_front();
        check(it.req_c, exec_ok, it.exec_ok);
        check("R8", rsvd, it.rsvd);
        @(posedge clk);
        #1;
        check(it.req_t, truth, it.truth_nx);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int vals[5] = '{0, 1, 127, 128, 255};
    #(CLK_PERIOD * 2);
    check("R1", truth, 1'b0);                  // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1", truth, 1'b0);

    // R2/R3/R4: sweep of boundary pairs, all selectors, always-execute
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int s = 0; s < 8; s++)
          drive(1'b1, vals[i], vals[j], 3'(s), 2'b00,
                (s < 4) ? "R2" : (s < 6) ? "R3" : "R4");

    // R5: set truth, then idle cycles with operands that would clear it
    drive(1'b1, 3, 3, 3'd4, 2'b00, "R3");
    drive(1'b0, 3, 4, 3'd4, 2'b00, "R5");
    drive(1'b0, 9, 2, 3'd0, 2'b00, "R5");

    // R4: unused selectors with truth set, then cleared
    drive(1'b1, 5, 5, 3'd6, 2'b00, "R4");
    drive(1'b1, 5, 6, 3'd7, 2'b01, "R4");
    drive(1'b1, 5, 6, 3'd4, 2'b00, "R3");
    drive(1'b1, 5, 5, 3'd7, 2'b10, "R4");

    // R7/R9: predicated compares, truth currently 0
    drive(1'b1, 7, 7, 3'd4, 2'b01, "R9");       // denied
    drive(1'b1, 7, 7, 3'd4, 2'b10, "R7");       // allowed, sets
    drive(1'b1, 1, 2, 3'd4, 2'b10, "R9");       // denied now
    drive(1'b1, 1, 2, 3'd4, 2'b01, "R7");       // allowed, clears
    drive(1'b1, 2, 1, 3'd2, 2'b11, "R9");       // reserved: denied
    drive(1'b0, 2, 1, 3'd2, 2'b01, "R7");
    drive(1'b1, 2, 1, 3'd2, 2'b00, "R2");       // sets
    drive(1'b1, 2, 1, 3'd5, 2'b11, "R8");
    drive(1'b0, 0, 0, 3'd0, 2'b01, "R7");
    drive(1'b0, 0, 0, 3'd0, 2'b10, "R7");

    @(negedge clk); cmp_en = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule